// File: doc/BRIEF.md
# Serial-In Latched Octal Output Controller

This block is the digital control for an eight-channel low-side output driver. A host shifts channel on/off data one bit at a time into an eight-stage shift chain on each rising edge of a slow serial clock. The last stage of the chain is driven out on a serial output. Several such blocks can therefore be chained: the host clocks one long bit stream through all of them and then strobes them together.

A strobe input moves the chain contents into an output buffer. The buffer follows the chain while the strobe is high and holds its value once the strobe goes low. An active-low enable forces all eight drive outputs off without disturbing the buffer. Reset clears both the chain and the buffer.

All four host inputs are asynchronous to the block. They are brought into a fast system clock domain through two-flop synchronizers. That clock must run at least eight times faster than the serial clock.

Top module: `serial_latched_driver`

## Requirements
- R1: The shift chain has eight stages. Each rising edge of `serClk` moves every stage up by one, and the value of `serIn` enters stage 0.
- R2: `serOut` always shows stage 7. A bit shifted in appears on `serOut` after eight serial clocks and leaves it on the ninth, so that a downstream device receives it.
- R3: While `latchStb` is high, the output buffer follows the shift chain. A shift made during a high strobe reaches `drive`.
- R4: When `latchStb` falls, the buffer keeps the chain value it last held, and later shifts leave `drive` unchanged.
- R5: Serial clocks given while `latchStb` is low do not change `drive`.
- R6: While `outEnN` is 1, all `drive` bits are 0. When `outEnN` returns to 0, `drive` again shows the buffer. The buffer is kept while the outputs are disabled.
- R7: A buffer bit of 1 turns its channel on (`drive` bit 1). Buffer bit k drives `drive[k]`. The first of eight shifted bits lands in stage 7 and so controls `drive[7]`.
- R8: While `rstN` is low, the shift chain and the buffer are cleared. After reset, `drive` is 0 and `serOut` is 0.
- R9: Each host input passes through a two-stage synchronizer. A change of any input shows at the outputs within four system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock; data shifts on its rising edge |
| serIn | input | 1 | Serial data input |
| latchStb | input | 1 | Strobe: buffer is transparent while high and holds when low |
| outEnN | input | 1 | Active-low output enable |
| serOut | output | 1 | Last shift stage, used for cascading |
| drive | output | 8 | Channel on/off controls, 1 = on |

## Verification
The assertions check on every cycle the following:
- a detected serial edge lasts a single cycle;
- each shift advances the whole chain and presents the old stage 6 on `serOut`;
- the buffer stays stable whenever no load is requested;
- the outputs stay off while the synchronized enable is inactive and during reset.

The bench scenarios cover what a per-cycle property cannot:
- the end-to-end bit order from the serial stream to the channels;
- transparency while the strobe is held high;
- the hold after the strobe falls;
- the cascade stream on `serOut`;
- enable overriding the outputs and then restoring them.

// File: rtl/sld_pkg.sv
package sld_pkg;
  // Commands from the control unit to the datapath
  typedef struct packed {
    logic shiftEn;  // one-cycle pulse per detected serial clock rise
    logic bufLoad;  // buffer takes the chain value this cycle
  } sldStrobes_t;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[s] <= RST_VAL;
      end else if (s == 0) begin
        stageQ[s] <= asyncIn;
      end else begin
        stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/sld_ctrl.sv
module sld_ctrl
  import sld_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClkS,
  input  logic        stbS,
  output sldStrobes_t strb
);
  logic serClkPrev;
  logic stbPrev;
  logic clkRise;
  logic stbFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkPrev <= 1'b0;
      stbPrev    <= 1'b0;
    end else begin
      serClkPrev <= serClkS;
      stbPrev    <= stbS;
    end
  end

  assign clkRise = serClkS & ~serClkPrev;
  assign stbFall = stbPrev & ~stbS;

  always_comb begin
    strb.shiftEn = clkRise;
    // transparent while high, plus one capture at the falling edge
    strb.bufLoad = stbS | stbFall;
  end

  // R1: an edge detect never produces two consecutive shift pulses
  p_single_shift_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> !strb.shiftEn);
endmodule

// File: rtl/sld_datapath.sv
module sld_datapath
  import sld_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sldStrobes_t       strb,
  input  logic              serInS,
  input  logic              outEnNS,
  output logic              serOut,
  output logic [NUM_CH-1:0] drive
);
  localparam int LAST = NUM_CH - 1;

  logic [NUM_CH-1:0] chainQ;
  logic [NUM_CH-1:0] bufQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= '0;
    end else if (strb.shiftEn) begin
      chainQ <= {chainQ[LAST-1:0], serInS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ <= '0;
    end else if (strb.bufLoad) begin
      bufQ <= chainQ;
    end
  end

  assign serOut = chainQ[LAST];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_gate
    assign drive[k] = bufQ[k] & ~outEnNS;
  end

  // R1: every shift advances the whole chain by one stage
  p_chain_advance_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> chainQ[LAST:1] == $past(chainQ[LAST-1:0]));
  // R2: after a shift the serial output carries the former stage below the top
  p_serout_cascade_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> serOut == $past(chainQ[LAST-1]));
  // R4: without a load request the buffer holds
  p_buffer_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.bufLoad |=> $stable(bufQ));
endmodule

// File: rtl/serial_latched_driver.sv
module serial_latched_driver
  import sld_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serIn,
  input  logic              latchStb,
  input  logic              outEnN,
  output logic              serOut,
  output logic [NUM_CH-1:0] drive
);
  localparam int NUM_IN = 4;
  // bit order: {outEnN, latchStb, serIn, serClk}; enable resets to inactive
  localparam logic [NUM_IN-1:0] SYNC_RST = 4'b1000;

  logic [NUM_IN-1:0] syncVec;
  sldStrobes_t       strb;

  sld_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({outEnN, latchStb, serIn, serClk}),
    .syncOut (syncVec)
  );

  sld_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serClkS (syncVec[0]),
    .stbS    (syncVec[2]),
    .strb    (strb)
  );

  sld_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .serInS  (syncVec[1]),
    .outEnNS (syncVec[3]),
    .serOut  (serOut),
    .drive   (drive)
  );

  // R6: enable held inactive at the pin for the synchronizer depth keeps outputs off
  p_disable_forces_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outEnN, 2) && $past(outEnN, 1)) |-> drive == '0);
  // R8: reset leaves every output off
  p_reset_outputs_off_r8: assert property (@(posedge clk)
    !rstN |=> drive == '0);
endmodule

// File: tb/serial_latched_driver_bench.sv
module serial_latched_driver_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b0;
  logic       serIn = 1'b0;
  logic       latchStb = 1'b0;
  logic       outEnN = 1'b1;
  logic       serOut;
  logic [7:0] drive;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = '0;

  always #10 clk = ~clk;

  serial_latched_driver u_serial_latched_driver (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serIn(serIn),
    .latchStb(latchStb), .outEnN(outEnN), .serOut(serOut), .drive(drive)
  );

  // {outEnN, data}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'hA5}, {1'b0, 8'h01}, {1'b0, 8'h80},
    {1'b1, 8'hFF}, {1'b0, 8'h0F}, {1'b0, 8'h00}
  };

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    serIn = b;
    waitCyc(5);
    serClk = 1'b1;
    waitCyc(5);
    serClk = 1'b0;
    model = {model[6:0], b};
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic pulseStb;
    latchStb = 1'b1;
    waitCyc(6);
    latchStb = 1'b0;
    waitCyc(6);
  endtask

  initial begin
    fork
      begin : watchdog
        waitCyc(150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin : main
        waitCyc(4);
        check("R8 reset drive", drive, 8'h00);
        check("R8 reset serOut", {7'b0, serOut}, 8'h00);
        rstN = 1'b1;
        waitCyc(4);
        check("R8 drive after reset", drive, 8'h00);

        // table walk: R1 R7 R3 R6
        foreach (VEC[i]) begin
          outEnN = VEC[i][8];
          sendByte(VEC[i][7:0]);
          check("R2 serOut is stage 7", {7'b0, serOut}, {7'b0, VEC[i][7]});
          pulseStb();
          check("R7 R1 table drive", drive, VEC[i][8] ? 8'h00 : VEC[i][7:0]);
        end

        // R5: shifting without strobe leaves outputs alone
        outEnN = 1'b0;
        sendByte(8'h3C);
        pulseStb();
        check("R7 load 3C", drive, 8'h3C);
        sendByte(8'hC3);
        waitCyc(4);
        check("R5 no strobe no change", drive, 8'h3C);
        pulseStb();
        check("R4 strobe loads C3", drive, 8'hC3);

        // R6: enable override and restore
        outEnN = 1'b1;
        waitCyc(4);
        check("R6 disable forces off", drive, 8'h00);
        sendByte(8'h11);
        outEnN = 1'b0;
        waitCyc(4);
        check("R6 re-enable restores buffer", drive, 8'hC3);
        check("R9 enable latency", drive, 8'hC3);

        // R3 transparency while strobe held high, R4 hold after fall
        latchStb = 1'b1;
        waitCyc(6);
        check("R3 transparent follows chain", drive, model);
        sendBit(1'b1);
        waitCyc(4);
        check("R3 shift during high strobe", drive, model);
        latchStb = 1'b0;
        waitCyc(6);
        begin
          logic [7:0] held;
          held = model;
          sendBit(1'b0);
          sendBit(1'b1);
          waitCyc(4);
          check("R4 hold after strobe fall", drive, held);
        end

        // R2 cascade: first byte streams out of serOut
        sendByte(8'hB2);
        for (int k = 1; k < 8; k++) begin
          sendBit(1'b0);
          waitCyc(2);
          check("R2 cascade serOut", {7'b0, serOut}, {7'b0, model[7]});
          check("R2 cascade bit order", {7'b0, serOut}, {7'b0, 1'(8'hB2 >> (7 - k))});
        end

        // R8 reset mid-operation
        sendByte(8'hFF);
        pulseStb();
        check("R7 all on", drive, 8'hFF);
        rstN = 1'b0;
        waitCyc(3);
        check("R8 reset clears drive", drive, 8'h00);
        check("R8 reset clears serOut", {7'b0, serOut}, 8'h00);
        rstN = 1'b1;
        model = '0;
        waitCyc(2);
        pulseStb();
        check("R8 cleared chain loads zero", drive, 8'h00);
        disable watchdog;
      end
    join
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule